// File: doc/BRIEF.md
# Down-Counting Compare Timer

The block is a register-mapped timer whose counter steps downward. A word-wide register bus gives access to five registers: control, status, load, compare and a read-only counter. The counter advances on a divided version of an external clock-enable strobe. When the counter steps onto the compare value, a sticky flag is raised. That flag can drive an interrupt line and can also change a compare output pin.

Software chooses what happens when the counter passes zero. In reload mode the counter takes the load value again. In free-run mode it wraps to all ones. To schedule an event N ticks ahead, software writes the current count minus N into the compare register while the counter keeps running. The clock-source field and the four low-power gating bits are storage only and have no effect on the timer.

Top module: `cmp_down_timer`

## Requirements
- R1: After reset the registers read as follows. Control (byte address 0x00) reads 0, status (0x04) reads 0, load (0x08) reads all ones, compare (0x0C) reads 0 and counter (0x10) reads all ones. The irq and cmp_out outputs are 0.
- R2: The prescaler field sits in control bits 15:4 and holds P. The counter decrements once every P+1 cycles in which tick_en is high, and only while the enable bit (control bit 0) is 1. Cycles with tick_en low do not advance the counter.
- R3: A decrement from zero behaves according to the reload bit (control bit 3). When the bit is 1, the counter takes the load value. When it is 0, the counter becomes all ones.
- R4: With the overwrite bit (control bit 17) at 1, a write to the load register also places the written value in the counter. With the bit at 0, the counter is unchanged by the write.
- R5: Status bit 0 (the compare flag) becomes 1 on the decrement that brings the counter equal to the compare register.
- R6: Writing 1 to status bit 0 clears the compare flag. Writing 0 leaves the flag unchanged.
- R7: irq is high exactly when the compare flag is 1 and the interrupt-enable bit (control bit 2) is 1. Clearing the enable bit masks irq and keeps the flag.
- R8: The output mode sits in control bits 23:22. On each compare event, mode 1 toggles the pin, mode 2 drives it to 0 and mode 3 drives it to 1. Mode 0 holds cmp_out at 0.
- R9: With the enable-mode bit (control bit 1) at 1, a write that takes the enable bit from 0 to 1 restarts the counter. It restarts from the load value when the reload bit is 1 and from all ones when it is 0. Without the enable-mode bit, re-enabling keeps the current count.
- R10: Writing control with bit 16 set resets every register on the next cycle, and bit 16 reads 0 again afterwards.
- R11: Control bits 25:18 are stored and read back. Control bits 31:26 read 0. Writes to the counter address are ignored.
- R12: Writing compare = C - N, at the edge where the counter leaves value C, raises the flag N decrements after C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer clock-enable strobe |
| addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Compare interrupt |
| cmp_out | output | 1 | Compare output pin |

## Verification
The bench builds the block with its default values: a 32-bit counter, a 12-bit prescaler and a 5-bit address. Because the counter is full width, the wrap to all ones and the restart to all ones are checked against the real 32-bit maximum. Because the prescaler is full width, a prescale of 3 can be written through the normal control field and its divide-by-four spacing checked against the counter read-back.

// File: rtl/cmp_down_timer.sv
`timescale 1ns/1ps
module cmp_down_timer #(
  parameter int CW = 32,
  parameter int PW = 12,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data,
  output logic          irq,
  output logic          cmp_out
);
  localparam int B_EN    = 0;
  localparam int B_EMOD  = 1;
  localparam int B_IE    = 2;
  localparam int B_RLD   = 3;
  localparam int B_PRLO  = 4;
  localparam int B_PRHI  = B_PRLO + PW - 1;
  localparam int B_SWR   = B_PRHI + 1;
  localparam int B_OVW   = B_SWR + 1;
  localparam int B_OMLO  = B_OVW + 5;
  localparam int CTL_W   = B_OMLO + 4;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_STS = AW'(4);
  localparam logic [AW-1:0] A_LD  = AW'(8);
  localparam logic [AW-1:0] A_CMP = AW'(12);
  localparam logic [AW-1:0] A_CNT = AW'(16);

  logic [CTL_W-1:0] ctrl_q;
  logic [CW-1:0]    load_q, cmp_q, cnt_q, cnt_nxt;
  logic [PW-1:0]    pcnt_q;
  logic             flag_q, pin_q;

  wire en      = ctrl_q[B_EN];
  wire rld     = ctrl_q[B_RLD];
  wire swr_q   = ctrl_q[B_SWR];
  wire [1:0] omode = ctrl_q[B_OMLO+1:B_OMLO];
  wire [PW-1:0] presc = ctrl_q[B_PRHI:B_PRLO];

  wire wr_ctl = wr_en && addr == A_CTL;
  wire wr_sts = wr_en && addr == A_STS;
  wire wr_ld  = wr_en && addr == A_LD;
  wire wr_cmp = wr_en && addr == A_CMP;

  wire restart = wr_ctl && wr_data[B_EN] && wr_data[B_EMOD] && !en;
  wire ld_ovw  = wr_ld && ctrl_q[B_OVW];
  wire step    = en && tick_en;
  wire fire    = step && (pcnt_q >= presc);
  wire dec     = fire && !ld_ovw && !restart;
  wire hit     = dec && (cnt_nxt == cmp_q);

  assign cnt_nxt = (cnt_q == '0) ? (rld ? load_q : MAXV) : cnt_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || swr_q) begin
      ctrl_q <= '0;
      load_q <= MAXV;
      cmp_q  <= '0;
      cnt_q  <= MAXV;
      pcnt_q <= '0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (wr_ctl) ctrl_q <= wr_data[CTL_W-1:0];
      if (wr_ld)  load_q <= wr_data;
      if (wr_cmp) cmp_q  <= wr_data;

      if (restart)
        cnt_q <= wr_data[B_RLD] ? load_q : MAXV;
      else if (ld_ovw)
        cnt_q <= wr_data;
      else if (dec)
        cnt_q <= cnt_nxt;

      if (restart || ld_ovw) pcnt_q <= '0;
      else if (step)         pcnt_q <= fire ? '0 : pcnt_q + 1'b1;

      if (hit)                          flag_q <= 1'b1;
      else if (wr_sts && wr_data[0])    flag_q <= 1'b0;

      if (hit) begin
        case (omode)
          2'd1:    pin_q <= ~pin_q;
          2'd2:    pin_q <= 1'b0;
          2'd3:    pin_q <= 1'b1;
          default: pin_q <= pin_q;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rd_data = {{(CW-CTL_W){1'b0}}, ctrl_q};
      A_STS:   rd_data = {{(CW-1){1'b0}}, flag_q};
      A_LD:    rd_data = load_q;
      A_CMP:   rd_data = cmp_q;
      A_CNT:   rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end

  assign irq     = flag_q & ctrl_q[B_IE];
  assign cmp_out = (omode != 2'd0) & pin_q;

  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt_q == $past(cmp_q)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en && !swr_q) |=> $stable(cnt_q));
  p_swr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swr_q |=> (ctrl_q == '0 && cnt_q == MAXV && !flag_q));
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wr_data[0] && !hit) |=> !flag_q);
  p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> !irq);
  p_pin_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (omode == 2'd0) |-> !cmp_out);
endmodule

// File: tb/cmp_down_timer_tb.sv
`timescale 1ns/1ps
module cmp_down_timer_tb;
  logic clk = 0, rst_n = 0, tick_en = 1, wr_en = 0;
  logic [4:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq, cmp_out;
  int runs = 0, fails = 0;

  localparam logic [31:0] EN = 32'h1, EMOD = 32'h2, IE = 32'h4, RLD = 32'h8;
  localparam logic [31:0] OVW = 32'h2_0000, SWR = 32'h1_0000;

  always #10 clk = ~clk;

  cmp_down_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .cmp_out(cmp_out));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic arm(logic [31:0] start, logic [31:0] cmpv, logic [31:0] bits);
    wr(0, OVW);
    wr(4, 1);
    wr(8, start);
    wr(12, cmpv);
    wr(0, bits | EN | OVW);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v);  chk("R1 ctrl", v, 0);
    rd(4, v);  chk("R1 status", v, 0);
    rd(8, v);  chk("R1 load", v, 32'hFFFF_FFFF);
    rd(12, v); chk("R1 compare", v, 0);
    rd(16, v); chk("R1 counter", v, 32'hFFFF_FFFF);
    chk("R1 irq", irq, 0);
    chk("R1 cmp_out", cmp_out, 0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(0, OVW); wr(8, 100);
    rd(16, v); chk("R4 overwrite load", v, 100);
    wr(0, EN | OVW | (32'd3 << 4));
    cyc(3); rd(16, v); chk("R2 before divided tick", v, 100);
    cyc(1); rd(16, v); chk("R2 first divided tick", v, 99);
    cyc(4); rd(16, v); chk("R2 second divided tick", v, 98);
    tick_en = 0;
    cyc(10); rd(16, v); chk("R2 no strobe no step", v, 98);
    tick_en = 1;
  endtask

  task automatic t_zero;
    logic [31:0] v;
    arm(3, 32'h1234_5678, RLD);
    cyc(3); rd(16, v); chk("R3 reach zero", v, 0);
    cyc(1); rd(16, v); chk("R3 reload from load", v, 3);
    arm(1, 32'h1234_5678, 0);
    cyc(2); rd(16, v); chk("R3 wrap to max", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_flag_irq;
    logic [31:0] v;
    arm(20, 15, 0);
    cyc(4); rd(4, v); chk("R5 flag before match", v, 0);
    cyc(1); rd(4, v); chk("R5 flag on match", v, 1);
    chk("R7 irq masked", irq, 0);
    wr(0, EN | OVW | IE); chk("R7 irq enabled", irq, 1);
    wr(0, EN | OVW);      chk("R7 irq masked again", irq, 0);
    rd(4, v); chk("R7 flag kept", v, 1);
    wr(4, 0); rd(4, v); chk("R6 write zero no effect", v, 1);
    wr(4, 1); rd(4, v); chk("R6 write one clears", v, 0);
  endtask

  task automatic t_pin;
    arm(10, 8, 32'd3 << 22);
    cyc(1); chk("R8 set mode before", cmp_out, 0);
    cyc(1); chk("R8 set mode", cmp_out, 1);
    arm(10, 8, 0);
    chk("R8 disconnect", cmp_out, 0);
    arm(10, 8, 32'd2 << 22);
    cyc(1); chk("R8 clear mode before", cmp_out, 1);
    cyc(1); chk("R8 clear mode", cmp_out, 0);
    arm(10, 8, 32'd1 << 22);
    cyc(2); chk("R8 toggle up", cmp_out, 1);
    arm(10, 8, 32'd1 << 22);
    cyc(2); chk("R8 toggle down", cmp_out, 0);
  endtask

  task automatic t_schedule;
    logic [31:0] c, v;
    arm(1000, 1, 0);
    cyc(3);
    rd(16, c);
    wr(12, c - 10);
    cyc(8); rd(4, v); chk("R12 not yet", v, 0);
    cyc(1); rd(4, v); chk("R12 event after N", v, 1);
  endtask

  task automatic t_enmod;
    logic [31:0] c, v;
    wr(0, 0);
    rd(16, c);
    wr(8, 50);
    rd(16, v); chk("R4 no overwrite", v, c);
    wr(0, EN | EMOD | RLD);
    rd(16, v); chk("R9 restart from load", v, 50);
    cyc(2); rd(16, v); chk("R9 counting after restart", v, 48);
    wr(0, EMOD);
    wr(0, EN | EMOD);
    rd(16, v); chk("R9 restart from max", v, 32'hFFFF_FFFF);
    wr(0, 0);
    rd(16, c);
    wr(0, EN);
    rd(16, v); chk("R9 plain enable keeps count", v, c);
    wr(0, 0);
  endtask

  task automatic t_store_swr;
    logic [31:0] c, v;
    wr(0, 32'hFFFE_0000);
    rd(0, v); chk("R11 stored-only bits", v, 32'h03FE_0000);
    wr(0, 0);
    rd(16, c);
    wr(16, 32'h1234);
    rd(16, v); chk("R11 counter write ignored", v, c);
    wr(8, 7); wr(12, 9);
    wr(0, SWR | EN);
    rd(0, v); chk("R10 swr visible", v, 32'h1_0001);
    cyc(1);
    rd(0, v);  chk("R10 ctrl reset", v, 0);
    rd(8, v);  chk("R10 load reset", v, 32'hFFFF_FFFF);
    rd(12, v); chk("R10 compare reset", v, 0);
    rd(16, v); chk("R10 counter reset", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset;
    t_prescale;
    t_zero;
    t_flag_irq;
    t_pin;
    t_schedule;
    t_enmod;
    t_store_swr;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #2000000;
    runs++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule